// File: doc/BRIEF.md
# Prioritised IRQ/FIQ Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines, organised in banks of 32, and presents them to a processor as two request outputs. One is a normal interrupt (IRQ) and the other is a fast interrupt (FIQ). Each line passes through a mask. Software can force a request on any line. A per-line level register sends the line to either output and gives it a 6-bit priority, where a smaller value is more urgent. A global threshold can filter out lines whose priority is not urgent enough.

Each output has its own arbiter. When an output is low, the arbiter searches every clock for the most urgent eligible line. When it finds one, it raises the output and latches that line's number and priority into readable registers. The output and the latched values then stay frozen until software writes the matching agreement bit. Writing that bit drops the output and lets the next decision happen.

A single-cycle register bus gives access to every register. Reads are combinational and writes take effect on the clock edge that samples them. A soft-reset command returns all state to its reset values, and a status bit reports when that reset has finished.

Top module: `prio_intc`

## Requirements
- R1: After reset every line is masked, and every level register reads 0, which means routed to IRQ at the most urgent priority. The threshold register (0x024) reads 0xFF. Both outputs are low. The status register (0x004) bit 0 reads 1 from the first clock edge after reset is released.
- R2: Bank b sits at 0x100 + 32*b, and line n is at bank n/32, bit n%32. Each bit written as 1 to mask-clear (+0x08) clears that mask bit. Each bit written as 1 to mask-set (+0x0C) sets it. Bits written as 0 leave the mask unchanged. The mask reads back at +0x04.
- R3: Each bit written as 1 to software-set (+0x10) sets that line's software request. Each bit written as 1 to software-clear (+0x14) clears it. Reading +0x10 returns the current software requests.
- R4: A line is pending when (raw input OR software request) AND NOT mask. The IRQ-pending register (+0x18) shows pending lines routed to IRQ. The FIQ-pending register (+0x1C) shows pending lines routed to FIQ.
- R5: Line n's level register sits at 0x200 + 4*n. Bit 0 selects the output (0 for IRQ, 1 for FIQ) and bits 7:2 hold the priority. Bit 1 and bits 31:8 always read 0.
- R6: When an output is low, the next clock edge picks the eligible line with the smallest priority value, breaking ties by the lowest line number. That edge raises the output. The active number reads in bits 6:0 of 0x010 (IRQ) or 0x014 (FIQ). The active priority reads in bits 5:0 of 0x018 (IRQ) or 0x01C (FIQ).
- R7: While an output is high, its active number and priority stay unchanged whatever the inputs do, until the matching agreement bit is written.
- R8: Writing 1 to bit 0 of 0x020 drops IRQ at that edge, and bit 1 does the same for FIQ. Each bit leaves the other output alone. The next edge makes a new decision.
- R9: When the threshold is not 0xFF, a line is eligible only if its priority value is strictly less than the threshold. A threshold of 0xFF disables the filter.
- R10: When a decision finds no eligible line, the output stays low. The number register and the priority register for that output then read 0xFFFFFF80, meaning bits 31:7 are set and the field is 0. While the output is high, bits 31:7 read 0.
- R11: Writing 1 to bit 1 of 0x000 starts a soft reset. Status bit 0 reads 0 after that edge. The next edge restores every R1 reset value and sets status bit 0 back to 1.
- R12: The raw register (+0x00) returns the unmasked input lines of the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | NUM_LINES | Level interrupt inputs |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
Register reads are due in the same cycle as the address, so the bench samples them one time step after driving the address at a falling edge. A write is visible just after the rising edge that samples it. An output that is low decides on the next rising edge. After an agreement write, the output is checked low just after that edge and re-checked one edge later with the new winner. A soft reset takes two edges: status reads 0 after the first edge and 1 after the second, and the bench samples both points.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 irq_out,
  output logic                 fiq_out
);
  localparam int BANKS = NUM_LINES / 32;
  localparam int PW = 6;
  localparam int NW = 7;
  localparam logic [11:0] A_CFG = 12'h000, A_STAT = 12'h004;
  localparam logic [11:0] A_INUM = 12'h010, A_FNUM = 12'h014;
  localparam logic [11:0] A_IPRI = 12'h018, A_FPRI = 12'h01C;
  localparam logic [11:0] A_AGREE = 12'h020, A_THR = 12'h024;

  logic [NUM_LINES-1:0]         mask_q, sw_q, route_q;
  logic [NUM_LINES-1:0][PW-1:0] prio_q;
  logic [7:0]                   thr_q;
  logic                         soft_pend, rst_done;
  logic                         irq_q, fiq_q, irq_spur, fiq_spur;
  logic [NW-1:0]                irq_num, fiq_num;
  logic [PW-1:0]                irq_pri, fiq_pri;

  wire wr_en     = bus_sel & bus_wr;
  wire bank_hit  = bus_addr[11:8] == 4'h1;
  wire lvl_hit   = bus_addr[11:9] == 3'b001;
  wire soft_wr   = wr_en && bus_addr == A_CFG && bus_wdata[1];
  wire agree_irq = wr_en && bus_addr == A_AGREE && bus_wdata[0];
  wire agree_fiq = wr_en && bus_addr == A_AGREE && bus_wdata[1];

  wire [NUM_LINES-1:0] pend     = (line_in | sw_q) & ~mask_q;
  wire [NUM_LINES-1:0] pend_irq = pend & ~route_q;
  wire [NUM_LINES-1:0] pend_fiq = pend & route_q;

  function automatic logic [NW+PW:0] pick(input logic [NUM_LINES-1:0] req,
                                          input logic [NUM_LINES-1:0][PW-1:0] pr,
                                          input logic [7:0] thr);
    logic          found;
    logic [NW-1:0] n;
    logic [PW-1:0] p;
    found = 1'b0;
    n = '0;
    p = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i] && (thr == 8'hFF || {2'b00, pr[i]} < thr) && (!found || pr[i] < p)) begin
        found = 1'b1;
        n = NW'(i);
        p = pr[i];
      end
    end
    return {found, n, p};
  endfunction

  wire [NW+PW:0] irq_pick = pick(pend_irq, prio_q, thr_q);
  wire [NW+PW:0] fiq_pick = pick(pend_fiq, prio_q, thr_q);

  assign irq_out = irq_q;
  assign fiq_out = fiq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;  sw_q <= '0;  route_q <= '0;  prio_q <= '0;  thr_q <= 8'hFF;
      soft_pend <= 1'b0;  rst_done <= 1'b0;
      irq_q <= 1'b0;  irq_spur <= 1'b1;  irq_num <= '0;  irq_pri <= '0;
      fiq_q <= 1'b0;  fiq_spur <= 1'b1;  fiq_num <= '0;  fiq_pri <= '0;
    end else if (soft_pend) begin
      mask_q <= '1;  sw_q <= '0;  route_q <= '0;  prio_q <= '0;  thr_q <= 8'hFF;
      soft_pend <= 1'b0;  rst_done <= 1'b1;
      irq_q <= 1'b0;  irq_spur <= 1'b1;  irq_num <= '0;  irq_pri <= '0;
      fiq_q <= 1'b0;  fiq_spur <= 1'b1;  fiq_num <= '0;  fiq_pri <= '0;
    end else begin
      soft_pend <= soft_wr;
      rst_done  <= !soft_wr;
      if (wr_en && bus_addr == A_THR) thr_q <= bus_wdata[7:0];
      for (int b = 0; b < BANKS; b++) begin
        if (wr_en && bank_hit && bus_addr[7:5] == 3'(b)) begin
          case (bus_addr[4:2])
            3'd1:    mask_q[b*32 +: 32] <= bus_wdata;
            3'd2:    mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] & ~bus_wdata;
            3'd3:    mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] | bus_wdata;
            3'd4:    sw_q[b*32 +: 32]   <= sw_q[b*32 +: 32] | bus_wdata;
            3'd5:    sw_q[b*32 +: 32]   <= sw_q[b*32 +: 32] & ~bus_wdata;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < NUM_LINES; i++) begin
        if (wr_en && lvl_hit && bus_addr[8:2] == 7'(i)) begin
          route_q[i] <= bus_wdata[0];
          prio_q[i]  <= bus_wdata[7:2];
        end
      end
      if (irq_q) begin
        if (agree_irq) irq_q <= 1'b0;
      end else begin
        irq_q    <= irq_pick[NW+PW];
        irq_spur <= !irq_pick[NW+PW];
        irq_num  <= irq_pick[NW+PW] ? irq_pick[NW+PW-1:PW] : '0;
        irq_pri  <= irq_pick[NW+PW] ? irq_pick[PW-1:0] : '0;
      end
      if (fiq_q) begin
        if (agree_fiq) fiq_q <= 1'b0;
      end else begin
        fiq_q    <= fiq_pick[NW+PW];
        fiq_spur <= !fiq_pick[NW+PW];
        fiq_num  <= fiq_pick[NW+PW] ? fiq_pick[NW+PW-1:PW] : '0;
        fiq_pri  <= fiq_pick[NW+PW] ? fiq_pick[PW-1:0] : '0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata = {31'd0, rst_done};
      A_INUM:  bus_rdata = {{25{irq_spur}}, irq_num};
      A_FNUM:  bus_rdata = {{25{fiq_spur}}, fiq_num};
      A_IPRI:  bus_rdata = {{25{irq_spur}}, 1'b0, irq_pri};
      A_FPRI:  bus_rdata = {{25{fiq_spur}}, 1'b0, fiq_pri};
      A_THR:   bus_rdata = {24'd0, thr_q};
      default: ;
    endcase
    for (int b = 0; b < BANKS; b++) begin
      if (bank_hit && bus_addr[7:5] == 3'(b)) begin
        case (bus_addr[4:2])
          3'd0:    bus_rdata = line_in[b*32 +: 32];
          3'd1:    bus_rdata = mask_q[b*32 +: 32];
          3'd4:    bus_rdata = sw_q[b*32 +: 32];
          3'd6:    bus_rdata = pend_irq[b*32 +: 32];
          3'd7:    bus_rdata = pend_fiq[b*32 +: 32];
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      if (lvl_hit && bus_addr[8:2] == 7'(i))
        bus_rdata = {24'd0, prio_q[i], 1'b0, route_q[i]};
    end
  end
endmodule

module prio_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [1:0]  wd,
  input logic [31:0] bus_rdata,
  input logic        irq_out,
  input logic        fiq_out
);
  wire soft_wr   = bus_sel && bus_wr && bus_addr == 12'h000 && wd[1];
  wire agree_irq = bus_sel && bus_wr && bus_addr == 12'h020 && wd[0];
  wire agree_fiq = bus_sel && bus_wr && bus_addr == 12'h020 && wd[1];
  wire rd        = bus_sel && !bus_wr;

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (!irq_out && !fiq_out);

  p_irq_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !agree_irq && !soft_wr && !$past(soft_wr) |=> irq_out);

  p_fiq_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out && !agree_fiq && !soft_wr && !$past(soft_wr) |=> fiq_out);

  p_irq_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && agree_irq |=> !irq_out);

  p_fiq_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out && agree_fiq |=> !fiq_out);

  p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_wr |=> ##1 (!irq_out && !fiq_out));

  p_level_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr[11:9] == 3'b001 |-> (bus_rdata & 32'hFFFFFF02) == 32'd0);

  p_active_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == 12'h010 && irq_out |-> (bus_rdata & 32'hFFFFFF80) == 32'd0);
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wd(bus_wdata[1:0]), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] line_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;
  int checks = 0, fails = 0;

  localparam logic [31:0] SPUR = 32'hFFFFFF80;
  localparam logic [127:0] VEC [8] = '{
    {64'h0000_0000_0000_0008, 32'h0000_0003, SPUR},
    {64'h0000_0000_0000_0408, 32'h0000_000A, SPUR},
    {64'h0000_0100_0000_0400, 32'h0000_000A, SPUR},
    {64'h0000_0100_0010_0000, 32'h0000_0028, SPUR},
    {64'h0000_0000_0000_0080, SPUR,          32'h0000_0007},
    {64'h0004_0000_0000_0088, 32'h0000_0003, 32'h0000_0007},
    {64'h0004_0000_0000_0009, 32'h0000_0000, 32'h0000_0032},
    {64'h0000_0000_0000_0000, SPUR,          SPUR}
  };

  prio_intc #(.NUM_LINES(64)) u_prio_intc (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic redecide();
    wr(12'h020, 32'h3);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs low in reset", {62'd0, irq_out, fiq_out}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    rd(12'h004, d); chk("R1 status done", d, 1);
    rd(12'h104, d); chk("R1 bank0 masked", d, 32'hFFFFFFFF);
    rd(12'h124, d); chk("R1 bank1 masked", d, 32'hFFFFFFFF);
    rd(12'h214, d); chk("R1 level line5", d, 0);
    rd(12'h024, d); chk("R1 threshold", d, 32'hFF);
    rd(12'h010, d); chk("R1 R10 irq spurious", d, SPUR);
    chk("R1 outputs low", {62'd0, irq_out, fiq_out}, 64'd0);

    @(negedge clk); line_in = 64'h0000_0005_0000_0000;
    rd(12'h120, d); chk("R12 raw bank1", d, 32'h5);
    @(negedge clk); line_in = '0;

    wr(12'h108, 32'h0000_00F0);
    rd(12'h104, d); chk("R2 mask clear", d, 32'hFFFFFF0F);
    wr(12'h10C, 32'h0000_0010);
    rd(12'h104, d); chk("R2 mask set", d, 32'hFFFFFF1F);
    wr(12'h108, 32'hFFFFFFFF);
    wr(12'h128, 32'hFFFFFFFF);
    rd(12'h124, d); chk("R2 bank1 unmasked", d, 0);

    wr(12'h20C, 32'h14);
    wr(12'h228, 32'h08);
    wr(12'h2A0, 32'h08);
    wr(12'h21C, 32'h05);
    wr(12'h2C8, 32'h11);
    wr(12'h250, 32'h24);
    wr(12'h204, 32'hFF);
    rd(12'h204, d); chk("R5 level bits", d, 32'hFD);
    wr(12'h204, 32'h0);
    rd(12'h21C, d); chk("R5 fiq route", d, 32'h05);

    for (int k = 0; k < 8; k++) begin
      @(negedge clk); line_in = VEC[k][127:64];
      redecide();
      rd(12'h010, d); chk($sformatf("R6 irq vector %0d", k), d, VEC[k][63:32]);
      rd(12'h014, d); chk($sformatf("R6 fiq vector %0d", k), d, VEC[k][31:0]);
      chk($sformatf("R6 R10 outputs vector %0d", k), {62'd0, irq_out, fiq_out},
          {62'd0, VEC[k][63:32] != SPUR, VEC[k][31:0] != SPUR});
    end
    rd(12'h018, d); chk("R10 irq priority spurious", d, SPUR);

    @(negedge clk); line_in = 64'h0000_0000_0000_0408;
    redecide();
    rd(12'h018, d); chk("R6 irq priority", d, 32'h2);

    @(negedge clk); line_in = 64'h0000_0000_0000_0088;
    wr(12'h10C, 32'h8);
    rd(12'h118, d); chk("R4 masked line not pending", d, 0);
    rd(12'h11C, d); chk("R4 fiq pending", d, 32'h80);
    wr(12'h108, 32'h8);
    rd(12'h118, d); chk("R4 irq pending", d, 32'h8);

    wr(12'h130, 32'h4);
    rd(12'h130, d); chk("R3 sw set readback", d, 32'h4);
    rd(12'h138, d); chk("R3 R4 sw pending", d, 32'h4);
    wr(12'h134, 32'h4);
    rd(12'h130, d); chk("R3 sw clear", d, 0);

    @(negedge clk); line_in = 64'h0000_0000_0000_0008;
    redecide();
    rd(12'h010, d); chk("R7 setup line3", d, 32'h3);
    @(negedge clk); line_in = 64'h0000_0000_0000_0408;
    @(posedge clk); @(posedge clk); #1;
    rd(12'h010, d); chk("R7 frozen number", d, 32'h3);
    rd(12'h018, d); chk("R7 frozen priority", d, 32'h5);
    chk("R7 irq stays high", {63'd0, irq_out}, 1);

    @(negedge clk); line_in = 64'h0000_0000_0000_0488;
    @(posedge clk); #1;
    wr(12'h020, 32'h2);
    @(posedge clk); #1;
    wr(12'h020, 32'h1);
    chk("R8 irq dropped", {63'd0, irq_out}, 0);
    chk("R8 fiq untouched", {63'd0, fiq_out}, 1);
    @(posedge clk); #1;
    chk("R8 irq raised again", {63'd0, irq_out}, 1);
    rd(12'h010, d); chk("R8 new winner", d, 32'hA);

    @(negedge clk); line_in = 64'h0000_0000_0000_0408;
    wr(12'h024, 32'h3);
    redecide();
    rd(12'h010, d); chk("R9 below threshold", d, 32'hA);
    wr(12'h024, 32'h2);
    redecide();
    rd(12'h010, d); chk("R9 equal not eligible", d, SPUR);
    chk("R9 R10 irq low", {63'd0, irq_out}, 0);
    wr(12'h024, 32'hFF);
    @(posedge clk); #1;
    rd(12'h010, d); chk("R9 filter off", d, 32'hA);

    wr(12'h000, 32'h2);
    rd(12'h004, d); chk("R11 status busy", d, 0);
    @(posedge clk); #1;
    rd(12'h004, d); chk("R11 status done", d, 1);
    rd(12'h104, d); chk("R11 mask restored", d, 32'hFFFFFFFF);
    rd(12'h024, d); chk("R11 threshold restored", d, 32'hFF);
    rd(12'h228, d); chk("R11 level restored", d, 0);
    chk("R11 outputs low", {62'd0, irq_out, fiq_out}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule